// File: doc/BRIEF.md
# Flash Write-Protect Command Gate

This block sits between the command decoder and the program/erase engine of a serial flash memory. Once the decoder has finished the address phase of a command, it presents the command class and the target page. The gate then decides, within one clock, whether the operation may start or must be dropped. The decision is based on a hardware write-protect pin and a per-sector protection vector. It also decides whether the sector protection register itself may be rewritten.

The memory is divided into five protection sectors, and the map is not uniform. The lowest sector is split into a small part at the bottom of the array and a large remainder; every other sector is the same size. Commands that set up protection stay accepted while the pin is holding off writes.

A decision is latched once per chip-select frame and held until chip select is released. At that point the gate returns to idle. A dropped command does nothing until then. A low level on the device reset input abandons the frame and keeps the gate idle for as long as the input stays low.

Top module: `wp_cmd_gate`

## Requirements
- R1: After the synchronous reset `rst`, `idle` is 1 and `go`, `ignore` and `reg_wr_en` are 0.
- R2: A program (class 1) or erase (class 2) command whose target sector has its `prot_bits` bit set, issued while the synchronised write-protect level is low, gives `ignore`=1 and `go`=0 in the cycle after `cmd_valid`.
- R3: A program or erase command gives `go`=1 and `ignore`=0 when the target sector bit is clear or the write-protect pin is high.
- R4: Page-to-sector mapping, with the sector index selecting a bit of `prot_bits`: pages 0–7 map to bit 0, pages 8–127 to bit 1, 128–255 to bit 2, 256–383 to bit 3 and 384–511 to bit 4.
- R5: A chip erase (class 3) is ignored when write-protect is low and any `prot_bits` bit is set; otherwise it gives `go`.
- R6: The protection-enable (class 4) and lockdown (class 5) commands always give `go`, whatever the write-protect level.
- R7: A protection-register write (class 6) gives `go`=1 and `reg_wr_en`=1 while write-protect is high. While write-protect is low it gives `ignore`=1 and `reg_wr_en`=0.
- R8: Read and other classes (0, 7) raise neither `go` nor `ignore`. The latched decision holds while `cs_n` stays low, and a further `cmd_valid` in the same frame has no effect. The cycle after `cs_n` is sampled high, all three decision outputs are 0 and `idle` is 1. A `cmd_valid` while `cs_n` is high is dropped.
- R9: While `dev_rst_n` is low, the decision outputs are cleared and `idle` is 1 from the next cycle, and `cmd_valid` is not acted on.
- R10: `wp_n` passes through two flip-flops that reset to the high level. A command uses the level `wp_n` had two clock edges before the edge that samples `cmd_valid`, so a change first seen on that same edge has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_rst_n | input | 1 | Device reset level, active low, aborts the frame |
| cs_n | input | 1 | Chip select, active low |
| wp_n | input | 1 | Asynchronous write-protect pin, active low |
| cmd_valid | input | 1 | Address phase complete, class and page valid |
| cmd_class | input | 3 | Decoded command class |
| page_addr | input | 9 | Target page address |
| prot_bits | input | 5 | Per-sector protection vector |
| go | output | 1 | Operation may run (held for the frame) |
| ignore | output | 1 | Operation dropped (held for the frame) |
| reg_wr_en | output | 1 | Protection register write allowed |
| idle | output | 1 | Gate is idle with chip select released |

## Verification
The hardest case to reach from the ports is the one-cycle window of the write-protect synchroniser. A command has to land on the very edge at which the new pin level enters the first flop. The stimulus drops `wp_n` on the same negative clock edge that raises `cmd_valid`, expects the old level to decide, and then repeats the command after three cycles to see the new level take effect. The second hard case is a second `cmd_valid` within one frame whose outcome would differ from the first. This is built by changing the protection vector between the two pulses.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  typedef enum logic [2:0] {
    CMD_READ     = 3'd0,
    CMD_PROG     = 3'd1,
    CMD_ERASE    = 3'd2,
    CMD_CHIP     = 3'd3,
    CMD_PROT_EN  = 3'd4,
    CMD_LOCK     = 3'd5,
    CMD_PROT_WR  = 3'd6,
    CMD_OTHER    = 3'd7
  } wpg_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEL  = 2'd1,
    ST_HOLD = 2'd2
  } wpg_state_e;
endpackage

// File: rtl/wpg_sync.sv
module wpg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/wpg_sector_map.sv
module wpg_sector_map #(
  parameter int PAGES      = 512,
  parameter int SECT_PAGES = 128,
  parameter int SUB_PAGES  = 8,
  localparam int PAGE_W    = $clog2(PAGES),
  localparam int NUM_SECT  = PAGES / SECT_PAGES + 1,
  localparam int SECT_W    = $clog2(NUM_SECT)
) (
  input  logic [PAGE_W-1:0] page_addr,
  output logic [SECT_W-1:0] sect_idx
);
  logic [PAGE_W-1:0] quot;

  always_comb begin
    quot = page_addr / PAGE_W'(SECT_PAGES);
    if (page_addr < PAGE_W'(SUB_PAGES)) sect_idx = '0;
    else                                sect_idx = SECT_W'(quot + PAGE_W'(1));
  end
endmodule

// File: rtl/wpg_decide.sv
module wpg_decide
  import wpg_pkg::*;
#(
  parameter int NUM_SECT = 5,
  localparam int SECT_W  = $clog2(NUM_SECT)
) (
  input  logic [2:0]          cmd_class,
  input  logic [SECT_W-1:0]   sect_idx,
  input  logic [NUM_SECT-1:0] prot_bits,
  input  logic                wp_active,
  output logic                allow,
  output logic                block,
  output logic                wr_ok
);
  wpg_cmd_e cls;
  logic     gated;
  logic     blk;

  always_comb begin
    cls   = wpg_cmd_e'(cmd_class);
    gated = 1'b0;
    blk   = 1'b0;
    wr_ok = 1'b0;
    case (cls)
      CMD_PROG, CMD_ERASE: begin
        gated = 1'b1;
        blk   = wp_active & prot_bits[sect_idx];
      end
      CMD_CHIP: begin
        gated = 1'b1;
        blk   = wp_active & (|prot_bits);
      end
      CMD_PROT_EN, CMD_LOCK: gated = 1'b1;
      CMD_PROT_WR: begin
        gated = 1'b1;
        blk   = wp_active;
        wr_ok = ~wp_active;
      end
      default: gated = 1'b0;
    endcase
    allow = gated & ~blk;
    block = gated & blk;
  end
endmodule

// File: rtl/wp_cmd_gate.sv
module wp_cmd_gate
  import wpg_pkg::*;
#(
  parameter int PAGES       = 512,
  parameter int SECT_PAGES  = 128,
  parameter int SUB_PAGES   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int PAGE_W     = $clog2(PAGES),
  localparam int NUM_SECT   = PAGES / SECT_PAGES + 1,
  localparam int SECT_W     = $clog2(NUM_SECT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dev_rst_n,
  input  logic                cs_n,
  input  logic                wp_n,
  input  logic                cmd_valid,
  input  logic [2:0]          cmd_class,
  input  logic [PAGE_W-1:0]   page_addr,
  input  logic [NUM_SECT-1:0] prot_bits,
  output logic                go,
  output logic                ignore,
  output logic                reg_wr_en,
  output logic                idle
);
  logic              wp_q;
  logic [SECT_W-1:0] sect_idx;
  logic              d_allow, d_block, d_wr;
  wpg_state_e        state;

  wpg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(wp_n), .q(wp_q)
  );

  wpg_sector_map #(.PAGES(PAGES), .SECT_PAGES(SECT_PAGES), .SUB_PAGES(SUB_PAGES)) u_map (
    .page_addr(page_addr), .sect_idx(sect_idx)
  );

  wpg_decide #(.NUM_SECT(NUM_SECT)) u_dec (
    .cmd_class(cmd_class), .sect_idx(sect_idx), .prot_bits(prot_bits),
    .wp_active(~wp_q), .allow(d_allow), .block(d_block), .wr_ok(d_wr)
  );

  always_ff @(posedge clk) begin
    if (rst || !dev_rst_n || cs_n) begin
      state     <= ST_IDLE;
      go        <= 1'b0;
      ignore    <= 1'b0;
      reg_wr_en <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_SEL: begin
          if (cmd_valid) begin
            state     <= ST_HOLD;
            go        <= d_allow;
            ignore    <= d_block;
            reg_wr_en <= d_wr;
          end else begin
            state <= ST_SEL;
          end
        end
        default: state <= ST_HOLD;
      endcase
    end
  end

  assign idle = (state == ST_IDLE);

  // R2/R3: a latched decision is never both run and drop
  a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(go && ignore));

  // R8: decision held through the frame
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (go && !cs_n && dev_rst_n) |=> go);

  // R8: chip select release clears the decision
  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!go && !ignore && !reg_wr_en && idle));

  // R9: device reset forces idle
  a_r9_abort: assert property (@(posedge clk) disable iff (rst)
    !dev_rst_n |=> (idle && !go && !ignore));

  // R7: register write only granted with the synchronised pin high
  a_r7_wp_high: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_wr_en) |-> $past(wp_q));

  // R7: register write implies go
  a_r7_with_go: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |-> go);
endmodule

// File: tb/wp_cmd_gate_bench.sv
module wp_cmd_gate_bench;
  logic       clk = 1'b0;
  logic       rst, dev_rst_n, cs_n, wp_n, cmd_valid;
  logic [2:0] cmd_class;
  logic [8:0] page_addr;
  logic [4:0] prot_bits;
  logic       go, ignore, reg_wr_en, idle;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wp_cmd_gate u_wp_cmd_gate (
    .clk(clk), .rst(rst), .dev_rst_n(dev_rst_n), .cs_n(cs_n), .wp_n(wp_n),
    .cmd_valid(cmd_valid), .cmd_class(cmd_class), .page_addr(page_addr),
    .prot_bits(prot_bits), .go(go), .ignore(ignore), .reg_wr_en(reg_wr_en),
    .idle(idle)
  );

  // {wp_n, prot[4:0], class[2:0], page[8:0], go, ignore, wr}
  localparam int NV = 20;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 5'b00001, 3'd1, 9'd7,   3'b010},  // R2 R4 page 7 -> bit0
    {1'b0, 5'b00001, 3'd1, 9'd8,   3'b100},  // R4 page 8 not bit0
    {1'b0, 5'b00010, 3'd2, 9'd8,   3'b010},  // R4 bit1 lower edge
    {1'b0, 5'b00010, 3'd2, 9'd127, 3'b010},  // R4 bit1 upper edge
    {1'b0, 5'b00010, 3'd1, 9'd128, 3'b100},  // R3
    {1'b0, 5'b00100, 3'd1, 9'd128, 3'b010},  // R4 bit2
    {1'b0, 5'b00100, 3'd1, 9'd255, 3'b010},  // R4
    {1'b0, 5'b01000, 3'd1, 9'd256, 3'b010},  // R4 bit3
    {1'b0, 5'b01000, 3'd1, 9'd384, 3'b100},  // R4
    {1'b0, 5'b10000, 3'd2, 9'd511, 3'b010},  // R4 bit4
    {1'b0, 5'b10000, 3'd2, 9'd383, 3'b100},  // R4
    {1'b1, 5'b11111, 3'd1, 9'd0,   3'b100},  // R3 pin high
    {1'b0, 5'b00000, 3'd3, 9'd0,   3'b100},  // R5 nothing protected
    {1'b0, 5'b00100, 3'd3, 9'd0,   3'b010},  // R5
    {1'b1, 5'b11111, 3'd3, 9'd0,   3'b100},  // R5 pin high
    {1'b0, 5'b11111, 3'd4, 9'd0,   3'b100},  // R6 enable
    {1'b0, 5'b11111, 3'd5, 9'd0,   3'b100},  // R6 lockdown
    {1'b1, 5'b11111, 3'd6, 9'd0,   3'b101},  // R7 allowed
    {1'b0, 5'b00000, 3'd6, 9'd0,   3'b010},  // R7 blocked
    {1'b0, 5'b11111, 3'd0, 9'd5,   3'b000}   // R8 read not gated
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual {go,ign,wr,idle}=%b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse_cmd(input logic [2:0] c, input logic [8:0] p);
    cmd_class = c; page_addr = p; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic release_cs();
    cs_n = 1'b1;
    @(negedge clk);
    chk("R8", {go, ignore, reg_wr_en, idle}, 4'b0001);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; dev_rst_n = 1'b1; cs_n = 1'b1; wp_n = 1'b1; cmd_valid = 1'b0;
    cmd_class = 3'd0; page_addr = '0; prot_bits = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {go, ignore, reg_wr_en, idle}, 4'b0001);

    for (int i = 0; i < NV; i++) begin
      wp_n = VEC[i][20]; prot_bits = VEC[i][19:15];
      repeat (3) @(negedge clk);
      cs_n = 1'b0;
      @(negedge clk);
      pulse_cmd(VEC[i][14:12], VEC[i][11:3]);
      chk($sformatf("R2-R8 vec%0d", i), {go, ignore, reg_wr_en, idle}, {VEC[i][2:0], 1'b0});
      release_cs();
    end

    // R8: second command in the same frame is dropped
    wp_n = 1'b0; prot_bits = 5'b00000;
    repeat (3) @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
    pulse_cmd(3'd1, 9'd300);
    prot_bits = 5'b11111;
    pulse_cmd(3'd1, 9'd300);
    repeat (2) @(negedge clk);
    chk("R8 hold", {go, ignore, reg_wr_en, idle}, 4'b1000);
    release_cs();

    // R8: command while deselected is dropped
    pulse_cmd(3'd1, 9'd0);
    chk("R8 cs high", {go, ignore, reg_wr_en, idle}, 4'b0001);

    // R9: device reset aborts and blocks commands
    wp_n = 1'b1;
    repeat (3) @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
    pulse_cmd(3'd4, 9'd0);
    chk("R9 pre", {go, ignore, reg_wr_en, idle}, 4'b1000);
    dev_rst_n = 1'b0;
    @(negedge clk);
    chk("R9 abort", {go, ignore, reg_wr_en, idle}, 4'b0001);
    pulse_cmd(3'd6, 9'd0);
    chk("R9 held", {go, ignore, reg_wr_en, idle}, 4'b0001);
    dev_rst_n = 1'b1;
    release_cs();

    // R10: change on the sampling edge is not yet seen
    wp_n = 1'b1; prot_bits = 5'b11111;
    repeat (3) @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
    wp_n = 1'b0;
    pulse_cmd(3'd1, 9'd10);
    chk("R10 old level", {go, ignore, reg_wr_en, idle}, 4'b1000);
    release_cs();
    repeat (2) @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
    pulse_cmd(3'd1, 9'd10);
    chk("R10 new level", {go, ignore, reg_wr_en, idle}, 4'b0100);
    release_cs();

    // R1: reset mid-frame
    cs_n = 1'b0;
    @(negedge clk);
    pulse_cmd(3'd1, 9'd10);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    cs_n = 1'b1;
    chk("R1 mid", {go, ignore, reg_wr_en, idle}, 4'b0001);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule